// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a 64-bit register window reach a private bank of 32-bit registers over a narrow request/acknowledge bus. The host packs an opcode, a byte address and the write data into one 64-bit command word. The bridge turns that word into exactly one transaction on the internal bus. It then reports completion by setting a sticky valid flag in a separate status word. On a read, the status word also carries the returned data. The host polls the status word until the flag appears.

A third host-visible word is a read-only descriptor of an attached serial controller. Its fields are fixed by parameters at build time.

The host gives up after a bounded number of polls. A guard counter therefore ends any transaction whose acknowledge does not arrive within `ACK_LIMIT` cycles. Because of this, the valid flag always comes back.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the status word (offset 0x18) reads as zero and no internal-bus request is pending.
- R2: Offset 0x08 returns the descriptor word, which has zeros in all unlisted bits. Its fields are:
  - bit 1: shift order, 1 = least significant bit first
  - bits 7:2: transfer width
  - bits 13:8: chip-select count
  - bit 14: clock polarity
  - bit 15: clock phase
  - bits 47:32: peripheral identifier

  Host writes to it change nothing.
- R3: A host write to offset 0x10 whose bits 63:62 hold 1 (read) or 2 (write) does three things. It clears the valid flag (status bit 32). It raises one internal request carrying address bits 44:32 and, for a write, data bits 31:0. It holds that request with a stable address and data until it ends.
- R4: Opcodes 0 and 3 in the command word raise no request and leave the whole status word unchanged.
- R5: When the acknowledge is seen during a request, the valid flag is set on the next clock edge. For a read, status bits 31:0 take the bus read data that was present in the acknowledge cycle.
- R6: A completed write leaves status bits 31:0 at their previous value.
- R7: A command word written while a request is outstanding is dropped. It is never issued later.
- R8: If no acknowledge arrives within `ACK_LIMIT` request cycles, the request is withdrawn and the valid flag is set. A read then reports 0xFFFFFFFF in bits 31:0, while a write leaves them unchanged. The bridge then accepts new commands normally.
- R9: A host read returns its data on the cycle after the read strobe. Offsets other than 0x08 and 0x18, including the command word, read as zero. Host writes to any offset other than 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, one cycle after the strobe |
| bus_req | output | 1 | Internal bus request, held until it ends |
| bus_we | output | 1 | Internal bus direction, 1 = write |
| bus_addr | output | BUS_AW | Internal register byte address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge |
| bus_rdata | input | 32 | Internal bus read data, valid with the acknowledge |

## Verification
The following properties are checked by assertions on every cycle:
- a request stays stable until it ends;
- issuing a command clears the valid flag;
- an acknowledge or timeout sets the valid flag;
- a write completion never disturbs the read data;
- the wait counter never passes its limit.

Some properties can only be shown by the bench scenarios:
- the data actually stored downstream and read back;
- a command dropped while busy never reaches the bus;
- nop and reserved opcodes have no effect;
- the timeout pattern, and recovery after it.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int unsigned HOST_DW = 64;
  localparam int unsigned BUS_DW  = 32;

  // Host word offsets; hardware decodes these
  localparam int unsigned OFS_DESC = 'h08;
  localparam int unsigned OFS_CMD  = 'h10;
  localparam int unsigned OFS_STAT = 'h18;

  // Command word field positions
  localparam int unsigned CMD_ADDR_LSB = 32;
  localparam int unsigned CMD_OP_LSB   = 62;

  // Status word valid flag position
  localparam int unsigned STAT_VALID_BIT = 32;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_RSV = 2'd3
  } ibr_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ibr_state_e;

endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode
  import ibr_pkg::*;
#(
  parameter int unsigned HOST_AW = 8,
  parameter int unsigned BUS_AW  = 13
) (
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic               cmd_go,
  output logic               cmd_we,
  output logic [BUS_AW-1:0]  cmd_addr,
  output logic [BUS_DW-1:0]  cmd_wdata
);

  localparam logic [HOST_AW-1:0] CMD_OFS = HOST_AW'(OFS_CMD);

  ibr_op_e op;
  logic    hit;

  always_comb begin
    hit       = host_wr && (host_addr == CMD_OFS);
    op        = ibr_op_e'(host_wdata[CMD_OP_LSB +: 2]);
    cmd_addr  = host_wdata[CMD_ADDR_LSB +: BUS_AW];
    cmd_wdata = host_wdata[BUS_DW-1:0];
    cmd_we    = (op == OP_WR);
    cmd_go    = hit && ((op == OP_RD) || (op == OP_WR));
  end

endmodule

// File: rtl/ibr_txn_ctrl.sv
module ibr_txn_ctrl
  import ibr_pkg::*;
#(
  parameter int unsigned BUS_AW    = 13,
  parameter int unsigned ACK_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_we,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [BUS_DW-1:0] cmd_wdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ack,
  output logic              issue,
  output logic              done,
  output logic              done_rd,
  output logic              done_to
);

  localparam int unsigned CW = $clog2(ACK_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_LIMIT - 1);

  ibr_state_e        state_q, state_d;
  logic [CW-1:0]     wait_q, wait_d;
  logic              we_q, we_d;
  logic [BUS_AW-1:0] addr_q, addr_d;
  logic [BUS_DW-1:0] wdata_q, wdata_d;
  logic              ack_seen, to_hit;

  always_comb begin
    ack_seen = (state_q == ST_BUSY) && bus_ack;
    to_hit   = (state_q == ST_BUSY) && !bus_ack && (wait_q == LAST);
    issue    = (state_q == ST_IDLE) && cmd_go;
    state_d  = state_q;
    wait_d   = wait_q;
    we_d     = we_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    if (issue) begin
      state_d = ST_BUSY;
      wait_d  = '0;
      we_d    = cmd_we;
      addr_d  = cmd_addr;
      wdata_d = cmd_we ? cmd_wdata : '0;
    end else if (ack_seen || to_hit) begin
      state_d = ST_IDLE;
      wait_d  = '0;
    end else if (state_q == ST_BUSY) begin
      wait_d  = wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      if (issue) begin
        we_q    <= we_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign bus_req   = (state_q == ST_BUSY);
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign done      = ack_seen || to_hit;
  assign done_rd   = !we_q;
  assign done_to   = to_hit;

  // R3: an open request keeps its address, data and direction
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !done) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

  // R7: a command arriving during a request does not alter it
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && cmd_go && !done) |=> ($stable(bus_addr) && $stable(bus_we)));

  // R8: the wait counter stays below the limit
  a_r8_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q < CW'(ACK_LIMIT));

  // R8: a timeout withdraws the request
  a_r8_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    done_to |=> !bus_req);

endmodule

// File: rtl/ibr_status.sv
module ibr_status
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              done,
  input  logic              done_rd,
  input  logic              done_to,
  input  logic [BUS_DW-1:0] rdata_in,
  output logic              valid,
  output logic [BUS_DW-1:0] rdata
);

  logic              valid_d;
  logic [BUS_DW-1:0] rdata_d;
  logic              en;

  always_comb begin
    valid_d = valid;
    rdata_d = rdata;
    if (issue) begin
      valid_d = 1'b0;
    end else if (done) begin
      valid_d = 1'b1;
      if (done_rd) rdata_d = done_to ? '1 : rdata_in;
    end
    en = issue || done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      rdata <= '0;
    end else if (en) begin
      valid <= valid_d;
      rdata <= rdata_d;
    end
  end

  // R3: issuing a command clears the flag
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !valid);

  // R5: completion sets the flag
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> valid);

  // R6: a write completion keeps the data field
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_rd) |=> $stable(rdata));

  // R4: without issue or completion the word holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !done) |=> ($stable(valid) && $stable(rdata)));

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned HOST_AW   = 8,
  parameter int unsigned BUS_AW    = 13,
  parameter int unsigned ACK_LIMIT = 64,
  parameter int unsigned SHIFT_LSB = 0,
  parameter int unsigned XFER_W    = 32,
  parameter int unsigned CS_COUNT  = 1,
  parameter int unsigned CLK_POL   = 0,
  parameter int unsigned CLK_PHA   = 0,
  parameter int unsigned PERIPH_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic [31:0]        bus_rdata
);

  localparam logic [HOST_AW-1:0] DESC_OFS = HOST_AW'(OFS_DESC);
  localparam logic [HOST_AW-1:0] STAT_OFS = HOST_AW'(OFS_STAT);
  localparam logic [HOST_DW-1:0] DESC_WORD = {
    16'h0, 16'(PERIPH_ID), 16'h0,
    1'(CLK_PHA), 1'(CLK_POL), 6'(CS_COUNT), 6'(XFER_W), 1'(SHIFT_LSB), 1'b0
  };

  logic              cmd_go, cmd_we;
  logic [BUS_AW-1:0] cmd_addr;
  logic [BUS_DW-1:0] cmd_wdata;
  logic              issue, done, done_rd, done_to;
  logic              st_valid;
  logic [BUS_DW-1:0] st_rdata;
  logic [HOST_DW-1:0] stat_word, rd_mux, rdata_q;

  ibr_cmd_decode #(.HOST_AW(HOST_AW), .BUS_AW(BUS_AW)) u_decode (
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .cmd_go     (cmd_go),
    .cmd_we     (cmd_we),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata)
  );

  ibr_txn_ctrl #(.BUS_AW(BUS_AW), .ACK_LIMIT(ACK_LIMIT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (cmd_go),
    .cmd_we    (cmd_we),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .issue     (issue),
    .done      (done),
    .done_rd   (done_rd),
    .done_to   (done_to)
  );

  ibr_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .done     (done),
    .done_rd  (done_rd),
    .done_to  (done_to),
    .rdata_in (bus_rdata),
    .valid    (st_valid),
    .rdata    (st_rdata)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STAT_VALID_BIT] = st_valid;
    stat_word[BUS_DW-1:0]     = st_rdata;
    if (host_addr == DESC_OFS)      rd_mux = DESC_WORD;
    else if (host_addr == STAT_OFS) rd_mux = stat_word;
    else                            rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
  end

  assign host_rdata = rdata_q;

  // R2: descriptor reads return the build-time word
  a_r2_desc: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == DESC_OFS) |=> (host_rdata == DESC_WORD));

  // R9: unmapped offsets read as zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != DESC_OFS && host_addr != STAT_OFS) |=> (host_rdata == '0));

  // R1: no request may start without a host command
  a_r1_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cmd_go));

endmodule

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT  = 24;
  localparam int P_SHIFT = 1;
  localparam int P_W    = 16;
  localparam int P_CS   = 3;
  localparam int P_POL  = 1;
  localparam int P_PHA  = 0;
  localparam int P_ID   = 'hA5C3;

  logic        clk, rst_n;
  logic        host_wr, host_rd;
  logic [7:0]  host_addr;
  logic [63:0] host_wdata, host_rdata;
  logic        bus_req, bus_we, bus_ack;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0;
  int fails  = 0;

  logic [45:0] exp_q[$];
  logic [31:0] mem [16];
  int          ack_delay = 0;
  logic        mute = 1'b0;
  int          ack_cnt;

  ind_reg_bridge #(
    .HOST_AW(8), .BUS_AW(13), .ACK_LIMIT(LIMIT),
    .SHIFT_LSB(P_SHIFT), .XFER_W(P_W), .CS_COUNT(P_CS),
    .CLK_POL(P_POL), .CLK_PHA(P_PHA), .PERIPH_ID(P_ID)
  ) u_ind_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Downstream register model
  assign bus_ack   = bus_req && !mute && (ack_cnt == ack_delay);
  assign bus_rdata = mem[bus_addr[5:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_cnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
    end else begin
      ack_cnt <= (!bus_req || bus_ack) ? 0 : ack_cnt + 1;
      if (bus_req && bus_ack && bus_we) mem[bus_addr[5:2]] <= bus_wdata;
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Monitor: every acknowledged transaction must match the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_req && bus_ack) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected txn actual=%h expected=none", {bus_we, bus_addr, bus_wdata});
      end else begin
        logic [45:0] e;
        e = exp_q.pop_front();
        if ({bus_we, bus_addr, bus_wdata} !== e) begin
          fails++;
          $display("FAIL R3 txn actual=%h expected=%h", {bus_we, bus_addr, bus_wdata}, e);
        end
      end
    end
  end

  task automatic hwrite(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  // Driver: issue a command and push the expected bus transaction
  task automatic cmd(input logic [1:0] op, input logic [12:0] a, input logic [31:0] d, input bit expect_txn);
    if (expect_txn) exp_q.push_back({op == 2'd2, a, (op == 2'd2) ? d : 32'h0});
    hwrite(8'h10, {op, 17'h0, a, d});
  endtask

  task automatic poll(output logic [63:0] st);
    int n;
    n = 0;
    st = '0;
    while (n < 1000) begin
      hread(8'h18, st);
      if (st[32]) break;
      n++;
    end
  endtask

  initial begin
    logic [63:0] r, st, prev;
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    hread(8'h18, r); check("R1 status after reset", r, 64'h0);
    check("R1 no request after reset", {63'h0, bus_req}, 64'h0);

    // R2 descriptor word
    hread(8'h08, r);
    check("R2 descriptor", r, {16'h0, 16'hA5C3, 16'h0, 1'b0, 1'b1, 6'd3, 6'd16, 1'b1, 1'b0});
    hwrite(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    hread(8'h08, r);
    check("R2 descriptor after write", r, {16'h0, 16'hA5C3, 16'h0, 1'b0, 1'b1, 6'd3, 6'd16, 1'b1, 1'b0});

    // R9 unmapped and command word read zero
    hread(8'h00, r); check("R9 offset 0 reads zero", r, 64'h0);
    hread(8'h10, r); check("R9 command word reads zero", r, 64'h0);

    // R3 write clears valid, R6 keeps data field
    ack_delay = 2;
    cmd(2'd2, 13'h004, 32'h1234_5678, 1'b1);
    hread(8'h18, r); check("R3 valid cleared while busy", {63'h0, r[32]}, 64'h0);
    poll(st); check("R6 write completes, data kept", st, 64'h1_0000_0000);

    // R5 read returns data
    ack_delay = 0;
    cmd(2'd1, 13'h004, 32'hDEAD_BEEF, 1'b1);
    poll(st); check("R5 read data immediate ack", st, 64'h1_1234_5678);

    ack_delay = 3;
    cmd(2'd2, 13'h008, 32'hCAFE_F00D, 1'b1);
    poll(st); check("R6 write keeps previous read data", st, 64'h1_1234_5678);

    ack_delay = 5;
    cmd(2'd1, 13'h008, 32'h0, 1'b1);
    poll(st); check("R5 read data delayed ack", st, 64'h1_CAFE_F00D);

    // R4 nop and reserved opcode
    prev = st;
    cmd(2'd0, 13'h00C, 32'hFFFF_0000, 1'b0);
    repeat (4) @(negedge clk);
    check("R4 nop raises no request", {63'h0, bus_req}, 64'h0);
    hread(8'h18, r); check("R4 nop keeps status", r, prev);
    cmd(2'd3, 13'h00C, 32'hFFFF_0000, 1'b0);
    repeat (4) @(negedge clk);
    hread(8'h18, r); check("R4 reserved opcode keeps status", r, prev);

    // R9 write to status offset ignored
    hwrite(8'h18, 64'h0);
    hread(8'h18, r); check("R9 status write ignored", r, prev);

    // R7 command while busy is dropped
    ack_delay = 8;
    cmd(2'd2, 13'h010, 32'h1111_1111, 1'b1);
    cmd(2'd2, 13'h014, 32'h2222_2222, 1'b0);
    poll(st);
    ack_delay = 0;
    cmd(2'd1, 13'h014, 32'h0, 1'b1);
    poll(st); check("R7 dropped write never stored", st, 64'h1_0000_0000);
    cmd(2'd1, 13'h010, 32'h0, 1'b1);
    poll(st); check("R7 first write stored", st, 64'h1_1111_1111);

    // R8 timeout on read and write, then recovery
    mute = 1'b1;
    cmd(2'd1, 13'h020, 32'h0, 1'b0);
    poll(st); check("R8 read timeout pattern", st, 64'h1_FFFF_FFFF);
    check("R8 request withdrawn", {63'h0, bus_req}, 64'h0);
    cmd(2'd2, 13'h020, 32'h5555_5555, 1'b0);
    poll(st); check("R8 write timeout keeps data", st, 64'h1_FFFF_FFFF);
    mute = 1'b0;
    cmd(2'd1, 13'h008, 32'h0, 1'b1);
    poll(st); check("R8 recovery after timeout", st, 64'h1_CAFE_F00D);

    repeat (4) @(negedge clk);
    check("R3 all expected transactions seen", 64'(exp_q.size()), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule